// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block keeps the run-time state of one device-side DMA channel of a USB controller and presents it as a single 32-bit status word. Its inputs are configuration writes, which come either from a control register write or from a completed descriptor load. It also sees the arbiter grant, packet-end, device-ended-transfer and byte-transferred strobes, and the DMA FIFO empty indication. From these it keeps a remaining byte counter, the channel enable and active flags, and three event flags that clear when software reads the word.

A disable request that arrives while the channel is being serviced does not stop the channel at once. The enable status stays set until the FIFO has drained. When a buffer runs out in the middle of a packet, the active flag is held through the next descriptor load so that the interrupted packet can finish under the new descriptor. When the channel is idle and the stored next-descriptor permission is set, the block raises a request to fetch the next descriptor.

Top module: `dma_chan_status`

## Requirements
- R1: Out of reset the status word is all zero. Its layout is: remaining byte count in bits 31:16, enable in bit 0, active in bit 1, end-of-transfer in bit 4, end-of-buffer in bit 5, descriptor-loaded in bit 6. Every other bit reads as zero.
- R2: A configuration write loads the byte count from `cfg_count`. While the channel is enabled, each `byte_stb` lowers the count by one. The count saturates at zero.
- R3: A configuration write with `cfg_enable`=1 sets the enable bit on the next cycle.
- R4: When a byte strobe takes the count from 1 to 0, the enable bit clears on the next cycle.
- R5: A `pkt_end` together with `dev_end` while the channel is enabled clears the enable bit on the next cycle.
- R6: A configuration write with `cfg_enable`=0 while the channel is active and the FIFO is not empty keeps enable set until a cycle with `fifo_empty`=1. Enable and active clear on the cycle after that. If the channel is not active, or the FIFO is empty, the write clears enable on the next cycle.
- R7: `ldnext_req` is high exactly when the enable bit is clear and the most recent configuration write carried `cfg_ldnext`=1.
- R8: A `grant` while enabled sets the active bit on the next cycle, and `pkt_end` clears it. A `grant` while disabled has no effect.
- R9: After a buffer-end stop the active bit stays set. It survives a following configuration write with `cfg_enable`=1 and clears at the next `pkt_end`. A configuration write with `cfg_enable`=0 and an empty FIFO clears it.
- R10: The end-of-buffer bit sets on the cycle after the count reaches zero by a byte strobe, and clears after a status read (`sts_rd`).
- R11: The end-of-transfer bit sets after a `pkt_end` with `dev_end` while enabled, and clears after a status read.
- R12: The descriptor-loaded bit sets after a configuration write with `cfg_from_desc`=1. It is not set by a write with `cfg_from_desc`=0, and it clears after a status read.
- R13: When a set event and a status read fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe (control write or descriptor load) |
| cfg_from_desc | input | 1 | The write comes from a descriptor load |
| cfg_enable | input | 1 | Requested channel enable |
| cfg_ldnext | input | 1 | Permission to load the next descriptor |
| cfg_count | input | 16 | Byte count to load |
| grant | input | 1 | Arbiter selects this channel as highest-priority requester |
| pkt_end | input | 1 | Packet transfer completed |
| dev_end | input | 1 | Device side ended the transfer |
| byte_stb | input | 1 | One byte transferred |
| fifo_empty | input | 1 | DMA FIFO is empty |
| sts_rd | input | 1 | Software reads the status word |
| status | output | 32 | Status word |
| ldnext_req | output | 1 | Request to fetch the next descriptor |

## Verification
The count and end-of-buffer behaviour is swept over every load value from 0 to 6 combined with 0 to 8 byte strobes. This separates the plain decrement, the exact 1-to-0 stop (the only case that drops enable and sets the flag), overrun strobes that must saturate, and a zero load that must never stop the channel. Directed sequences cover the other cases:
- disabling with a full FIFO versus an empty one, or with an idle channel;
- a device-ended transfer versus a buffer stop, which decides whether the active flag survives;
- reloads with and without enable;
- control-sourced versus descriptor-sourced writes;
- a read in the same cycle as a flag set event.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int STS_W   = 32;
  localparam int EN_POS  = 0;
  localparam int ACT_POS = 1;
  localparam int ETR_POS = 4;
  localparam int EBF_POS = 5;
  localparam int DLD_POS = 6;
  localparam int CNT_LSB = 16;

  // index of each clear-on-read flag in the flag bank
  typedef enum int unsigned {
    FL_ETR = 0,
    FL_EBF = 1,
    FL_DLD = 2
  } flag_idx_e;
  localparam int NUM_FLAGS = 3;
endpackage

// File: rtl/dcs_count.sv
module dcs_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             byte_stb,
  input  logic             en,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_hit
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic step;
  assign step     = !cfg_wr && byte_stb && en && (cnt_q != ZERO);
  assign zero_hit = step && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= ZERO;
    else if (cfg_wr) cnt_q <= cfg_count;
    else if (step)   cnt_q <= cnt_q - ONE;
  end

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == ZERO && !cfg_wr) |=> (cnt_q == ZERO)); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!cfg_wr && byte_stb && en && cnt_q != ZERO) |=> (cnt_q == $past(cnt_q) - ONE)); // R2
endmodule

// File: rtl/dcs_enable.sv
module dcs_enable (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr,
  input  logic cfg_enable,
  input  logic cfg_ldnext,
  input  logic grant,
  input  logic pkt_end,
  input  logic dev_end,
  input  logic fifo_empty,
  input  logic zero_hit,
  output logic en_q,
  output logic act_q,
  output logic ldnext_req
);
  logic drain_q, ldnext_q;
  logic en_d, act_d, drain_d;
  logic dev_stop;

  assign dev_stop = pkt_end && dev_end && en_q;

  always_comb begin
    en_d    = en_q;
    act_d   = act_q;
    drain_d = drain_q;
    if (cfg_wr) begin
      if (cfg_enable) begin
        en_d    = 1'b1;
        drain_d = 1'b0;
      end else if (act_q && !fifo_empty) begin
        drain_d = 1'b1;
      end else begin
        en_d    = 1'b0;
        act_d   = 1'b0;
        drain_d = 1'b0;
      end
    end else begin
      if (drain_q && fifo_empty) begin
        en_d    = 1'b0;
        act_d   = 1'b0;
        drain_d = 1'b0;
      end else if (zero_hit || dev_stop) begin
        en_d    = 1'b0;
        drain_d = 1'b0;
      end
      if (pkt_end)
        act_d = 1'b0;
      else if (grant && en_q && !drain_q)
        act_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      act_q    <= 1'b0;
      drain_q  <= 1'b0;
      ldnext_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      act_q   <= act_d;
      drain_q <= drain_d;
      if (cfg_wr) ldnext_q <= cfg_ldnext;
    end
  end

  assign ldnext_req = ldnext_q && !en_q;

  AST_EN_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_enable) |=> en_q); // R3
  AST_EN_DRAIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (drain_q && !fifo_empty && !cfg_wr && !zero_hit && !dev_stop) |=> en_q); // R6
  AST_EN_DRAIN_DONE: assert property (@(posedge clk) disable iff (rst)
    (drain_q && fifo_empty && !cfg_wr) |=> (!en_q && !act_q)); // R6
  AST_ACT_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
    $rose(act_q) |-> $past(grant)); // R8
  AST_ACT_PKT_CLR: assert property (@(posedge clk) disable iff (rst)
    (pkt_end && !cfg_wr) |=> !act_q); // R8
endmodule

// File: rtl/dcs_flags.sv
module dcs_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] set_ev,
  input  logic          rd,
  output logic [NF-1:0] flags_q
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    logic f_r;
    always_ff @(posedge clk) begin
      if (rst)            f_r <= 1'b0;
      else if (set_ev[g]) f_r <= 1'b1;
      else if (rd)        f_r <= 1'b0;
    end
    assign flags_q[g] = f_r;

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set_ev[g] |=> flags_q[g]); // R13
    AST_FLAG_RD_CLR: assert property (@(posedge clk) disable iff (rst)
      (rd && !set_ev[g]) |=> !flags_q[g]); // R10
  end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_from_desc,
  input  logic             cfg_enable,
  input  logic             cfg_ldnext,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             grant,
  input  logic             pkt_end,
  input  logic             dev_end,
  input  logic             byte_stb,
  input  logic             fifo_empty,
  input  logic             sts_rd,
  output logic [31:0]      status,
  output logic             ldnext_req
);
  import dcs_pkg::*;

  logic [CNT_W-1:0]     cnt_q;
  logic                 zero_hit, en_q, act_q;
  logic [NUM_FLAGS-1:0] set_ev, flags_q;

  dcs_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_count(cfg_count),
    .byte_stb(byte_stb), .en(en_q), .cnt_q(cnt_q), .zero_hit(zero_hit)
  );

  dcs_enable u_enable (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_enable(cfg_enable),
    .cfg_ldnext(cfg_ldnext), .grant(grant), .pkt_end(pkt_end),
    .dev_end(dev_end), .fifo_empty(fifo_empty), .zero_hit(zero_hit),
    .en_q(en_q), .act_q(act_q), .ldnext_req(ldnext_req)
  );

  always_comb begin
    set_ev         = '0;
    set_ev[FL_ETR] = pkt_end && dev_end && en_q && !cfg_wr;
    set_ev[FL_EBF] = zero_hit;
    set_ev[FL_DLD] = cfg_wr && cfg_from_desc;
  end

  dcs_flags #(.NF(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set_ev(set_ev), .rd(sts_rd), .flags_q(flags_q)
  );

  always_comb begin
    status                       = '0;
    status[CNT_LSB +: CNT_W]     = cnt_q;
    status[EN_POS]               = en_q;
    status[ACT_POS]              = act_q;
    status[ETR_POS]              = flags_q[FL_ETR];
    status[EBF_POS]              = flags_q[FL_EBF];
    status[DLD_POS]              = flags_q[FL_DLD];
  end

  AST_ETR_RD_CLR: assert property (@(posedge clk) disable iff (rst)
    (sts_rd && !pkt_end) |=> !status[ETR_POS]); // R11
  AST_DLD_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_from_desc && sts_rd) |=> !status[DLD_POS]); // R12
endmodule

// File: tb/dma_chan_status_tb_top.sv
module dma_chan_status_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 0, cfg_from_desc = 0, cfg_enable = 0, cfg_ldnext = 0;
  logic [15:0] cfg_count = '0;
  logic        grant = 0, pkt_end = 0, dev_end = 0, byte_stb = 0;
  logic        fifo_empty = 1, sts_rd = 0;
  logic [31:0] status;
  logic        ldnext_req;
  int          checks = 0, failures = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  dma_chan_status dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_from_desc(cfg_from_desc),
    .cfg_enable(cfg_enable), .cfg_ldnext(cfg_ldnext), .cfg_count(cfg_count),
    .grant(grant), .pkt_end(pkt_end), .dev_end(dev_end), .byte_stb(byte_stb),
    .fifo_empty(fifo_empty), .sts_rd(sts_rd), .status(status),
    .ldnext_req(ldnext_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    cfg_wr = 0; grant = 0; pkt_end = 0; dev_end = 0; byte_stb = 0; sts_rd = 0;
  endtask

  task automatic cfg(input bit desc, input bit en, input bit ldn, input int cnt);
    cfg_wr = 1; cfg_from_desc = desc; cfg_enable = en; cfg_ldnext = ldn;
    cfg_count = 16'(cnt);
    cyc();
  endtask

  task automatic rd();
    sts_rd = 1; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R1 reset status", status, 32'h0);

    // sweep: load value x strobe count
    for (int ld = 0; ld <= 6; ld++) begin
      for (int k = 0; k <= 8; k++) begin
        cfg(1, 1, 0, ld);
        chk("R2 load count", {16'h0, status[31:16]}, 32'(ld));
        chk("R3 enable set", {31'h0, status[0]}, 32'h1);
        chk("R12 desc loaded", {31'h0, status[6]}, 32'h1);
        rd();
        chk("R12 desc read clr", {31'h0, status[6]}, 32'h0);
        for (int s = 0; s < k; s++) begin
          byte_stb = 1; cyc();
        end
        chk("R2 count after strobes", {16'h0, status[31:16]}, 32'((ld > k) ? ld - k : 0));
        chk("R4 enable after strobes", {31'h0, status[0]}, 32'((ld == 0 || k < ld) ? 1 : 0));
        chk("R10 end-of-buffer set", {31'h0, status[5]}, 32'((ld > 0 && k >= ld) ? 1 : 0));
        chk("R1 reserved bits", status & 32'h0000_FF8C, 32'h0);
        rd();
        chk("R10 end-of-buffer read clr", {31'h0, status[5]}, 32'h0);
      end
    end

    // device-ended transfer
    cfg(0, 1, 0, 10);
    grant = 1; cyc();
    chk("R8 active on grant", {31'h0, status[1]}, 32'h1);
    pkt_end = 1; dev_end = 1; cyc();
    chk("R5 enable clr on dev end", {31'h0, status[0]}, 32'h0);
    chk("R8 active clr on pkt end", {31'h0, status[1]}, 32'h0);
    chk("R11 end-of-transfer set", {31'h0, status[4]}, 32'h1);
    chk("R12 no desc flag on ctrl write", {31'h0, status[6]}, 32'h0);
    rd();
    chk("R11 end-of-transfer read clr", {31'h0, status[4]}, 32'h0);
    grant = 1; cyc();
    chk("R8 grant ignored disabled", {31'h0, status[1]}, 32'h0);

    // next-descriptor request
    cfg(0, 0, 1, 3);
    chk("R7 ldnext req when idle", {31'h0, ldnext_req}, 32'h1);
    cfg(0, 1, 1, 3);
    chk("R7 no ldnext req when enabled", {31'h0, ldnext_req}, 32'h0);

    // drain on disable while active
    grant = 1; cyc();
    fifo_empty = 0;
    cfg(0, 0, 0, 3);
    chk("R6 enable held while draining", {31'h0, status[0]}, 32'h1);
    cyc(); cyc();
    chk("R6 enable still held", {31'h0, status[0]}, 32'h1);
    fifo_empty = 1; cyc();
    chk("R6 enable clr after drain", {31'h0, status[0]}, 32'h0);
    chk("R6 active clr after drain", {31'h0, status[1]}, 32'h0);
    cfg(0, 1, 0, 3);
    fifo_empty = 0;
    cfg(0, 0, 0, 3);
    chk("R6 idle disable immediate", {31'h0, status[0]}, 32'h0);
    fifo_empty = 1;

    // active persists across buffer-end reload
    cfg(0, 1, 0, 2);
    grant = 1; cyc();
    byte_stb = 1; cyc();
    byte_stb = 1; cyc();
    chk("R9 enable off at buffer end", {31'h0, status[0]}, 32'h0);
    chk("R9 active kept at buffer end", {31'h0, status[1]}, 32'h1);
    cfg(1, 1, 0, 5);
    chk("R9 active kept across reload", {31'h0, status[1]}, 32'h1);
    pkt_end = 1; cyc();
    chk("R9 active clr on pkt end", {31'h0, status[1]}, 32'h0);
    cfg(0, 1, 0, 1);
    grant = 1; cyc();
    byte_stb = 1; cyc();
    cfg(1, 0, 0, 4);
    chk("R9 active clr by disabling reload", {31'h0, status[1]}, 32'h0);
    rd();

    // set and read in the same cycle
    cfg(0, 1, 0, 1);
    byte_stb = 1; sts_rd = 1; cyc();
    chk("R13 set wins over read", {31'h0, status[5]}, 32'h1);
    rd();
    chk("R13 later read clears", {31'h0, status[5]}, 32'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule